// File: doc/BRIEF.md
# DRAM Wake-Up and Self-Addressed Refresh Sequencer

This block brings an asynchronous DRAM out of power-up and keeps its contents alive. After reset it stays silent for a programmable pause. It then runs a fixed number of wake-up strobe cycles and raises a ready flag. From that point it schedules refresh at an even pace, so that all rows are covered within the retention period. Each refresh is a CAS-before-RAS cycle: the column strobe is already low when the row strobe falls, so the memory takes the row from its own internal counter. The memory controller therefore supplies no address and moves no data during the cycle.

The strobe pins are shared with the access controller. Before every cycle the sequencer raises a request and waits for a grant. While a cycle is in progress it asserts a drive flag that tells the controller to hand over both strobes. Refresh demands that cannot be served at once are counted in a small backlog. If the backlog overflows, the retention guarantee is lost. The ready flag then drops and the wake-up cycles run again, without a second pause.

All time values are counted in system clock cycles. The defaults are derived from a clock rate in MHz, the pause in microseconds, the row count and the retention time.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is asserted, the row and column strobes are high (inactive), the drive flag is low, the request is low and the ready flag is low.
- R2: After reset is released, the request stays low and no strobe moves for exactly PAUSE_CYC rising clock edges. The request is first seen high after the PAUSE_CYC-th edge.
- R3: A strobe cycle starts only on a clock edge where the request and the grant are both high. The strobes never move while the grant is withheld.
- R4: Each cycle lowers the column strobe first, with the row strobe still high. The row strobe falls CAS_LEAD_CYC cycles later and stays low for RAS_LOW_CYC cycles. Then both strobes rise together.
- R5: After the strobes rise, the drive flag stays high for PRECHG_CYC more cycles with both strobes high. Only then are the strobes released.
- R6: The ready flag rises on the edge that ends the WAKE_CYCLES-th completed wake-up cycle, and no earlier.
- R7: Once the ready flag is high, one refresh demand is added every REF_INTERVAL clock edges. The first demand makes the request visible right after the REF_INTERVAL-th edge.
- R8: Up to MAX_DEFER demands may wait for a grant. Each completed refresh cycle retires one of them. When the request is low between cycles, the number of completed refreshes equals the number of demands raised since the ready flag rose.
- R9: A demand that arrives while MAX_DEFER demands are already waiting clears the backlog and drops the ready flag. That happens on edge (MAX_DEFER+1)·REF_INTERVAL after the ready flag rose, when no grant is given. The request is raised again at once, with no pause, and WAKE_CYCLES new cycles are needed before the ready flag returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_req_o | output | 1 | Request for the strobe pins; held through the whole cycle |
| ref_gnt_i | input | 1 | Grant from the access controller, sampled while idle |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| strobe_drive_o | output | 1 | High while this block owns and drives the strobes |
| init_done_o | output | 1 | Ready flag: wake-up finished, normal traffic allowed |

## Verification
Several checks run on every clock. Embedded properties confirm that the row strobe only falls while the column strobe is low, and that driving begins only after a granted request. They also check that the request stays quiet during the pause, that the backlog stays within its bound, and that an overflow clears the backlog and reloads the wake-up count. Other properties need whole scenarios and are shown only by the bench. These are the exact phase lengths of each cycle, the pause length, and the wake-up count before ready. The bench also covers the tick spacing, the exact overflow instant when grants are withheld, and the equality of served refreshes and raised demands after randomly delayed grants.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    // Phases of one strobe cycle plus the power-up pause.
    typedef enum logic [2:0] {
        SEQ_PAUSE,
        SEQ_IDLE,
        SEQ_CAS_LEAD,
        SEQ_RAS_LOW,
        SEQ_PRECHG
    } seq_state_e;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dram_rfsh_interval.sv
module dram_rfsh_interval #(
    parameter int unsigned INTERVAL = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = en_i && (cnt_q == CW'(INTERVAL - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R7: a demand can only appear after the timer has been running
    a_r7_tick_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> $past(en_i));

endmodule

// File: rtl/dram_rfsh_backlog.sv
module dram_rfsh_backlog #(
    parameter int unsigned MAX_DEFER = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic retire_i,
    output logic pending_o,
    output logic overflow_o
);
    localparam int unsigned BW = $clog2(MAX_DEFER + 1);

    logic [BW-1:0] cnt_d, cnt_q;

    assign pending_o  = (cnt_q != '0);
    assign overflow_o = tick_i && !retire_i && (cnt_q == BW'(MAX_DEFER));

    always_comb begin
        cnt_d = cnt_q;
        if (overflow_o) begin
            cnt_d = '0;
        end else if (tick_i && !retire_i) begin
            cnt_d = cnt_q + BW'(1);
        end else if (retire_i && !tick_i && cnt_q != '0) begin
            cnt_d = cnt_q - BW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: deferred demands never exceed the allowed depth
    a_r8_backlog_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BW'(MAX_DEFER));

    // R9: an overflowing demand empties the backlog
    a_r9_overflow_clears: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> (cnt_q == '0));

endmodule

// File: rtl/dram_rfsh_cycle_fsm.sv
module dram_rfsh_cycle_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC    = 20000,
    parameter int unsigned CAS_LEAD_CYC = 2,
    parameter int unsigned RAS_LOW_CYC  = 5,
    parameter int unsigned PRECHG_CYC   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic gnt_i,
    output logic req_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic drive_o,
    output logic start_o,
    output logic done_o
);
    localparam int unsigned LONGEST = max_of4(PAUSE_CYC, CAS_LEAD_CYC, RAS_LOW_CYC, PRECHG_CYC);
    localparam int unsigned CNT_W   = (LONGEST > 1) ? $clog2(LONGEST + 1) : 1;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic in_cycle;

    assign in_cycle = (fsm_q.st == SEQ_CAS_LEAD) || (fsm_q.st == SEQ_RAS_LOW) ||
                      (fsm_q.st == SEQ_PRECHG);
    assign req_o    = in_cycle || ((fsm_q.st == SEQ_IDLE) && want_i);
    assign cas_n_o  = !((fsm_q.st == SEQ_CAS_LEAD) || (fsm_q.st == SEQ_RAS_LOW));
    assign ras_n_o  = (fsm_q.st != SEQ_RAS_LOW);
    assign drive_o  = in_cycle;

    always_comb begin
        fsm_d   = fsm_q;
        start_o = 1'b0;
        done_o  = 1'b0;
        unique case (fsm_q.st)
            SEQ_PAUSE: begin
                if (fsm_q.cnt == '0) fsm_d.st  = SEQ_IDLE;
                else                 fsm_d.cnt = fsm_q.cnt - CNT_W'(1);
            end
            SEQ_IDLE: begin
                if (want_i && gnt_i) begin
                    fsm_d.st  = SEQ_CAS_LEAD;
                    fsm_d.cnt = CNT_W'(CAS_LEAD_CYC - 1);
                    start_o   = 1'b1;
                end
            end
            SEQ_CAS_LEAD: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.st  = SEQ_RAS_LOW;
                    fsm_d.cnt = CNT_W'(RAS_LOW_CYC - 1);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - CNT_W'(1);
                end
            end
            SEQ_RAS_LOW: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.st  = SEQ_PRECHG;
                    fsm_d.cnt = CNT_W'(PRECHG_CYC - 1);
                end else begin
                    fsm_d.cnt = fsm_q.cnt - CNT_W'(1);
                end
            end
            SEQ_PRECHG: begin
                if (fsm_q.cnt == '0) begin
                    fsm_d.st = SEQ_IDLE;
                    done_o   = 1'b1;
                end else begin
                    fsm_d.cnt = fsm_q.cnt - CNT_W'(1);
                end
            end
            default: fsm_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st  <= SEQ_PAUSE;
            fsm_q.cnt <= CNT_W'(PAUSE_CYC - 1);
        end else begin
            fsm_q <= fsm_d;
        end
    end

    // R4: the row strobe may only fall while the column strobe is already low
    a_r4_ras_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> !cas_n_o);

    // R3: strobe ownership only follows a granted request
    a_r3_drive_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_o) |-> $past(req_o && gnt_i));

    // R2: nothing is requested or strobed during the power-up pause
    a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == SEQ_PAUSE) |-> (!req_o && ras_n_o && cas_n_o));

    // R5: ownership ends only after a cycle with both strobes high
    a_r5_release_precharged: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_o) |-> $past(ras_n_o && cas_n_o));

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_MHZ      = 100,
    parameter int unsigned PAUSE_US     = 200,
    parameter int unsigned ROW_COUNT    = 4096,
    parameter int unsigned RETENTION_MS = 64,
    parameter int unsigned PAUSE_CYC    = PAUSE_US * CLK_MHZ,
    parameter int unsigned REF_INTERVAL = (RETENTION_MS * 1000 * CLK_MHZ) / ROW_COUNT,
    parameter int unsigned WAKE_CYCLES  = 8,
    parameter int unsigned CAS_LEAD_CYC = 2,
    parameter int unsigned RAS_LOW_CYC  = 5,
    parameter int unsigned PRECHG_CYC   = 3,
    parameter int unsigned MAX_DEFER    = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_req_o,
    input  logic ref_gnt_i,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic strobe_drive_o,
    output logic init_done_o
);
    localparam int unsigned WAKE_W = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        logic              init_done;
        logic [WAKE_W-1:0] wake_left;
        logic              cyc_wake;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic tick, overflow, pending, retire, want;
    logic cyc_start, cyc_done;

    dram_rfsh_interval #(.INTERVAL(REF_INTERVAL)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (ctl_q.init_done),
        .tick_o (tick)
    );

    dram_rfsh_backlog #(.MAX_DEFER(MAX_DEFER)) u_backlog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .retire_i   (retire),
        .pending_o  (pending),
        .overflow_o (overflow)
    );

    dram_rfsh_cycle_fsm #(
        .PAUSE_CYC    (PAUSE_CYC),
        .CAS_LEAD_CYC (CAS_LEAD_CYC),
        .RAS_LOW_CYC  (RAS_LOW_CYC),
        .PRECHG_CYC   (PRECHG_CYC)
    ) u_cycle (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_i  (want),
        .gnt_i   (ref_gnt_i),
        .req_o   (ref_req_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .drive_o (strobe_drive_o),
        .start_o (cyc_start),
        .done_o  (cyc_done)
    );

    assign want        = ctl_q.init_done ? pending : (ctl_q.wake_left != '0);
    assign retire      = cyc_done && !ctl_q.cyc_wake && ctl_q.init_done;
    assign init_done_o = ctl_q.init_done;

    always_comb begin
        ctl_d = ctl_q;
        // a cycle that starts on the overflow edge already counts toward wake-up
        if (cyc_start) ctl_d.cyc_wake = !ctl_q.init_done || overflow;
        if (overflow) begin
            ctl_d.init_done = 1'b0;
            ctl_d.wake_left = WAKE_W'(WAKE_CYCLES);
        end else if (cyc_done && ctl_q.cyc_wake && !ctl_q.init_done &&
                     ctl_q.wake_left != '0) begin
            ctl_d.wake_left = ctl_q.wake_left - WAKE_W'(1);
            if (ctl_q.wake_left == WAKE_W'(1)) ctl_d.init_done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.init_done <= 1'b0;
            ctl_q.wake_left <= WAKE_W'(WAKE_CYCLES);
            ctl_q.cyc_wake  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R6: readiness is only declared when a strobe cycle has just finished
    a_r6_ready_after_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_o) |-> $past(cyc_done));

    // R9: an overflow withdraws readiness and reloads the wake-up count
    a_r9_rewake_on_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (!init_done_o && ctl_q.wake_left == WAKE_W'(WAKE_CYCLES)));

endmodule

// File: tb/dram_rfsh_seq_bench.sv
module dram_rfsh_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int P_PAUSE    = 50;
    localparam int P_WAKE     = 8;
    localparam int P_INTERVAL = 40;
    localparam int P_CAS      = 2;
    localparam int P_RAS      = 4;
    localparam int P_PRE      = 3;
    localparam int P_DEFER    = 3;

    localparam logic [2:0] PH_IDLE = 3'b011;
    localparam logic [2:0] PH_CAS  = 3'b101;
    localparam logic [2:0] PH_RAS  = 3'b100;
    localparam logic [2:0] PH_PRE  = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, ras_n, cas_n, drv, rdy;

    int total = 0;
    int bad = 0;
    int edge_cnt = 0;
    int wake_done = 0;
    int norm_done = 0;
    logic edge_gnt = 1'b0, edge_req = 1'b0;
    logic [2:0] prev_ph = PH_IDLE;
    int ph_len = 0;
    logic cyc_norm = 1'b0;

    dram_rfsh_seq #(
        .PAUSE_CYC    (P_PAUSE),
        .REF_INTERVAL (P_INTERVAL),
        .WAKE_CYCLES  (P_WAKE),
        .CAS_LEAD_CYC (P_CAS),
        .RAS_LOW_CYC  (P_RAS),
        .PRECHG_CYC   (P_PRE),
        .MAX_DEFER    (P_DEFER)
    ) u_dram_rfsh_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_req_o      (req),
        .ref_gnt_i      (gnt),
        .ras_n_o        (ras_n),
        .cas_n_o        (cas_n),
        .strobe_drive_o (drv),
        .init_done_o    (rdy)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int expected_ticks(input int edges);
        return edges / P_INTERVAL;
    endfunction

    function automatic int overflow_edge();
        return (P_DEFER + 1) * P_INTERVAL;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    always @(posedge clk) begin
        edge_cnt <= edge_cnt + 1;
        edge_gnt <= gnt;
        edge_req <= req;
    end

    // Port monitor: phase order and phase lengths of every strobe cycle
    always @(negedge clk) begin
        logic [2:0] ph;
        if (rst_n) begin
            ph = {drv, cas_n, ras_n};
            if (ph == prev_ph) begin
                ph_len++;
            end else begin
                if (prev_ph == PH_IDLE && ph == PH_CAS) begin
                    chk(edge_gnt && edge_req, "R3 start without granted request", {edge_req, edge_gnt}, 3);
                    cyc_norm = rdy;
                end else if (prev_ph == PH_CAS && ph == PH_RAS) begin
                    chk(ph_len == P_CAS, "R4 column lead length", ph_len, P_CAS);
                end else if (prev_ph == PH_RAS && ph == PH_PRE) begin
                    chk(ph_len == P_RAS, "R4 row low length", ph_len, P_RAS);
                end else if (prev_ph == PH_PRE && ph == PH_IDLE) begin
                    chk(ph_len == P_PRE, "R5 precharge length", ph_len, P_PRE);
                    if (cyc_norm) norm_done++;
                    else          wake_done++;
                end else begin
                    chk(1'b0, "R4 illegal strobe transition", ph, prev_ph);
                end
                ph_len = 1;
                prev_ph = ph;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int n, e0, w0, nd0, first_req;
        bit seen_drv, lost;
        void'($urandom(32'd20240611));

        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            step();
            chk(ras_n && cas_n && !drv && !req && !rdy, "R1 reset outputs",
                {ras_n, cas_n, drv, req, rdy}, 5'b11000);
        end
        gnt = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // R2: pause length
        n = 0;
        seen_drv = 1'b0;
        while (n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (drv || !ras_n || !cas_n) seen_drv = 1'b1;
            if (req) break;
        end
        chk(n == P_PAUSE, "R2 first request edge", n, P_PAUSE);
        chk(!seen_drv, "R2 strobes quiet in pause", seen_drv, 0);

        // R6: wake-up count with immediate grants
        n = 0;
        while (!rdy && n < 5000) begin step(); n++; end
        chk(wake_done == P_WAKE, "R6 wake cycles before ready", wake_done, P_WAKE);
        chk(norm_done == 0, "R6 no refresh counted during wake", norm_done, 0);

        // R7 / R9: withhold grants until the backlog overflows
        e0 = edge_cnt;
        gnt = 1'b0;
        first_req = -1;
        seen_drv = 1'b0;
        n = 0;
        while (rdy && n < 5000) begin
            step();
            n = edge_cnt - e0;
            if (req && first_req < 0) first_req = n;
            if (drv) seen_drv = 1'b1;
        end
        chk(first_req == P_INTERVAL, "R7 first demand edge", first_req, P_INTERVAL);
        chk(n == overflow_edge(), "R9 overflow edge", n, overflow_edge());
        chk(!seen_drv, "R3 no strobes without grant", seen_drv, 0);
        chk(req == 1'b1, "R9 immediate rewake request", req, 1);

        // R9 / R6: rewake under random grants
        w0 = wake_done;
        n = 0;
        while (!rdy && n < 5000) begin
            gnt = ($urandom % 2) == 0;
            step();
            n++;
        end
        chk(wake_done - w0 == P_WAKE, "R9 rewake cycle count", wake_done - w0, P_WAKE);
        chk(rdy == 1'b1, "R9 ready restored", rdy, 1);

        // R8: random grant delays, backlog must stay serviceable
        e0 = edge_cnt;
        nd0 = norm_done;
        lost = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            gnt = ($urandom % 3) != 0;
            if (k % 500 == 7) gnt = 1'b0;
            step();
            if (!rdy) lost = 1'b1;
        end
        chk(!lost, "R8 no overflow under random grants", lost, 0);
        n = expected_ticks(edge_cnt - e0);
        chk((norm_done - nd0) <= n && (norm_done - nd0) + P_DEFER + 1 >= n,
            "R8 refresh count within backlog", norm_done - nd0, n);

        // R8: drain and compare exactly
        gnt = 1'b1;
        n = 0;
        step();
        while ((req || drv) && n < 200) begin step(); n++; end
        chk(norm_done - nd0 == expected_ticks(edge_cnt - e0), "R8 served equals demanded",
            norm_done - nd0, expected_ticks(edge_cnt - e0));

        // R7: spacing of the next demand after the drain
        w0 = norm_done;
        repeat (P_INTERVAL * 4) step();
        chk(norm_done - nd0 == expected_ticks(edge_cnt - e0) ||
            norm_done - nd0 + 1 == expected_ticks(edge_cnt - e0),
            "R7 steady refresh pace", norm_done - nd0, expected_ticks(edge_cnt - e0));
        chk(norm_done - w0 >= 3, "R7 demands keep arriving", norm_done - w0, 4);

        finish_run();
    end

endmodule